// File: doc/BRIEF.md
# Compartment-Aware Peripheral Access Filter

This block sits in front of a set of peripherals and decides, for each bus request, whether the requesting compartment may reach the addressed peripheral. Each peripheral owns a small configuration word that selects its filtering mode. A request can pass freely, pass only for a fixed owner compartment (owner 0 admits every compartment), or pass only for compartments on a whitelist that also hold the peripheral's semaphore. A packed bank of secure-only bits, one per peripheral, further blocks non-secure traffic.

Configuration words and secure-only registers are written and read through a simple register port. Requests carry a peripheral index, a 3-bit compartment ID and a secure attribute. The current semaphore holder for the addressed peripheral comes in on inputs alongside the request. The decision and a deny-reason code are registered and appear one clock after the request strobe.

Top module: `periph_gate`

## Requirements
- R1: After reset every configuration word and every secure-only register reads back as 0, resp_valid is low, and any in-range request is granted.
- R2: A configuration write (cfg_sel=0) keeps only filter-enable (bit 0), semaphore-enable (bit 1), static owner (bits 6:4) and whitelist (bits 23:16). All other bits read back 0. A write or read at an index of NUM_ENTRIES or above stores nothing and reads 0.
- R3: Secure-only register k (cfg_sel=1, cfg_addr=k) bit j belongs to peripheral 32*k+j. It reads back what was written, and writes to a register number of SEC_REGS or above are ignored.
- R4: resp_valid is high exactly one clock after a cycle with req_valid high, and low otherwise. resp_grant is never high without resp_valid. resp_reason is 0 exactly when the request is granted.
- R5: A request whose index is NUM_ENTRIES or above is denied with reason 1.
- R6: With filter-enable clear, the compartment check passes for every compartment, whatever the semaphore-enable and owner fields hold.
- R7: With filter-enable set, semaphore-enable clear and static owner 0, every compartment passes the compartment check.
- R8: With filter-enable set, semaphore-enable clear and a nonzero static owner, only a compartment equal to the owner passes. Any other compartment is denied with reason 2.
- R9: With both filter-enable and semaphore-enable set, the static owner is ignored, and a compartment whose whitelist bit (bit 16 plus its ID) is clear is denied with reason 3.
- R10: In semaphore mode, a whitelisted request is granted only when sem_busy is high and sem_cid equals the requesting compartment. Otherwise it is denied with reason 5.
- R11: When the secure-only bit of an in-range peripheral is set, a request with req_secure low is denied with reason 4. Requests with req_secure high are unaffected.
- R12: Deny reasons are checked in this order: index (1), then compartment (2 or 3), then secure-only (4), then semaphore holder (5).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 1 | 0 selects a configuration word, 1 a secure-only register |
| cfg_addr | input | IDX_W | Peripheral index or secure-only register number |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Combinational read data for cfg_sel/cfg_addr |
| req_valid | input | 1 | Request strobe |
| req_idx | input | IDX_W | Addressed peripheral |
| req_cid | input | 3 | Requesting compartment |
| req_secure | input | 1 | Secure attribute of the request |
| sem_busy | input | 1 | Semaphore of the addressed peripheral is taken |
| sem_cid | input | 3 | Compartment holding that semaphore |
| resp_valid | output | 1 | Decision present |
| resp_grant | output | 1 | Access allowed |
| resp_reason | output | 3 | 0 grant, 1 index, 2 owner mismatch, 3 not whitelisted, 4 secure-only, 5 semaphore not held |

## Verification
A register write takes effect at the clock edge that samples it, so readback is due in the same low clock phase that follows that edge. A decision is due one edge after its request is sampled. The bench model latches its expected response at that same edge and compares resp_valid, resp_grant and resp_reason at every falling edge, so each check lands half a cycle after the edge that should have produced the value. Readbacks are sampled a short delay after the address is driven, away from any edge.

// File: rtl/periph_gate_pkg.sv
package periph_gate_pkg;

    localparam int CID_W = 3;
    localparam int WL_W  = 1 << CID_W;

    // Stored part of a configuration word
    typedef struct packed {
        logic [WL_W-1:0]  wlist;
        logic [CID_W-1:0] owner;
        logic             sem_en;
        logic             flt_en;
    } cfg_t;

    typedef enum logic [2:0] {
        RSN_OK     = 3'd0,
        RSN_RANGE  = 3'd1,
        RSN_OWNER  = 3'd2,
        RSN_WLIST  = 3'd3,
        RSN_SECURE = 3'd4,
        RSN_HOLDER = 3'd5
    } reason_e;

    typedef struct packed {
        logic    valid;
        logic    grant;
        reason_e reason;
    } resp_t;

    function automatic logic [31:0] cfg_to_word(cfg_t c);
        logic [31:0] w;
        w        = '0;
        w[0]     = c.flt_en;
        w[1]     = c.sem_en;
        w[6:4]   = c.owner;
        w[23:16] = c.wlist;
        return w;
    endfunction

    function automatic cfg_t word_to_cfg(logic [31:0] w);
        cfg_t c;
        c.flt_en = w[0];
        c.sem_en = w[1];
        c.owner  = w[6:4];
        c.wlist  = w[23:16];
        return c;
    endfunction

endpackage

// File: rtl/periph_gate_store.sv
module periph_gate_store
    import periph_gate_pkg::*;
#(
    parameter int NUM_ENTRIES = 40,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic             acc_sel,
    input  logic [IDX_W-1:0] acc_addr,
    input  logic [31:0]      wr_data,
    output logic [31:0]      rd_data,
    input  logic [IDX_W-1:0] lk_idx,
    output cfg_t             lk_cfg,
    output logic             lk_sec
);
    localparam int SEC_REGS = (NUM_ENTRIES + 31) / 32;
    localparam int SEC_AW   = (SEC_REGS > 1) ? $clog2(SEC_REGS) : 1;

    cfg_t        cfg_q [NUM_ENTRIES];
    cfg_t        cfg_d [NUM_ENTRIES];
    logic [31:0] sec_q [SEC_REGS];
    logic [31:0] sec_d [SEC_REGS];

    logic              acc_cfg_ok, acc_sec_ok, lk_ok;
    logic [SEC_AW-1:0] acc_reg, lk_reg;
    logic [4:0]        lk_bit;

    always_comb begin
        acc_cfg_ok = int'(acc_addr) < NUM_ENTRIES;
        acc_sec_ok = int'(acc_addr) < SEC_REGS;
        acc_reg    = SEC_AW'(acc_addr);
        lk_ok      = int'(lk_idx) < NUM_ENTRIES;
        lk_reg     = SEC_AW'(lk_idx >> 5);
        lk_bit     = 5'(lk_idx);
    end

    // next state
    always_comb begin
        for (int i = 0; i < NUM_ENTRIES; i++) cfg_d[i] = cfg_q[i];
        for (int k = 0; k < SEC_REGS; k++)    sec_d[k] = sec_q[k];
        if (wr_en) begin
            if (!acc_sel && acc_cfg_ok)
                cfg_d[acc_addr] = word_to_cfg(wr_data);
            else if (acc_sel && acc_sec_ok)
                sec_d[acc_reg] = wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ENTRIES; i++) cfg_q[i] <= '0;
            for (int k = 0; k < SEC_REGS; k++)    sec_q[k] <= '0;
        end else begin
            for (int i = 0; i < NUM_ENTRIES; i++) cfg_q[i] <= cfg_d[i];
            for (int k = 0; k < SEC_REGS; k++)    sec_q[k] <= sec_d[k];
        end
    end

    // read and lookup paths
    always_comb begin
        rd_data = '0;
        if (!acc_sel && acc_cfg_ok)
            rd_data = cfg_to_word(cfg_q[acc_addr]);
        else if (acc_sel && acc_sec_ok)
            rd_data = sec_q[acc_reg];
        lk_cfg = lk_ok ? cfg_q[lk_idx] : '0;
        lk_sec = lk_ok ? sec_q[lk_reg][lk_bit] : 1'b0;
    end

endmodule

// File: rtl/periph_gate_eval.sv
module periph_gate_eval
    import periph_gate_pkg::*;
(
    input  logic             in_range,
    input  cfg_t             cfg,
    input  logic             sec_only,
    input  logic [CID_W-1:0] cid,
    input  logic             secure,
    input  logic             sem_busy,
    input  logic [CID_W-1:0] sem_cid,
    output logic             grant,
    output reason_e          reason
);
    logic sem_mode, listed, owner_ok, holder_ok;

    always_comb begin
        sem_mode  = cfg.flt_en && cfg.sem_en;
        listed    = cfg.wlist[cid];
        owner_ok  = !cfg.flt_en || (cfg.owner == '0) || (cfg.owner == cid);
        holder_ok = sem_busy && (sem_cid == cid);

        if (!in_range)                     reason = RSN_RANGE;
        else if (sem_mode && !listed)      reason = RSN_WLIST;
        else if (!sem_mode && !owner_ok)   reason = RSN_OWNER;
        else if (sec_only && !secure)      reason = RSN_SECURE;
        else if (sem_mode && !holder_ok)   reason = RSN_HOLDER;
        else                               reason = RSN_OK;
        grant = (reason == RSN_OK);
    end

endmodule

// File: rtl/periph_gate.sv
module periph_gate
    import periph_gate_pkg::*;
#(
    parameter int NUM_ENTRIES = 40,
    parameter int IDX_W       = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_sel,
    input  logic [IDX_W-1:0] cfg_addr,
    input  logic [31:0]      cfg_wdata,
    output logic [31:0]      cfg_rdata,
    input  logic             req_valid,
    input  logic [IDX_W-1:0] req_idx,
    input  logic [2:0]       req_cid,
    input  logic             req_secure,
    input  logic             sem_busy,
    input  logic [2:0]       sem_cid,
    output logic             resp_valid,
    output logic             resp_grant,
    output logic [2:0]       resp_reason
);
    cfg_t    lk_cfg;
    logic    lk_sec;
    logic    in_range;
    logic    ev_grant;
    reason_e ev_reason;
    resp_t   resp_d, resp_q;

    assign in_range = int'(req_idx) < NUM_ENTRIES;

    periph_gate_store #(
        .NUM_ENTRIES (NUM_ENTRIES),
        .IDX_W       (IDX_W)
    ) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cfg_wr),
        .acc_sel  (cfg_sel),
        .acc_addr (cfg_addr),
        .wr_data  (cfg_wdata),
        .rd_data  (cfg_rdata),
        .lk_idx   (req_idx),
        .lk_cfg   (lk_cfg),
        .lk_sec   (lk_sec)
    );

    periph_gate_eval u_eval (
        .in_range (in_range),
        .cfg      (lk_cfg),
        .sec_only (lk_sec),
        .cid      (req_cid),
        .secure   (req_secure),
        .sem_busy (sem_busy),
        .sem_cid  (sem_cid),
        .grant    (ev_grant),
        .reason   (ev_reason)
    );

    always_comb begin
        resp_d = '0;
        if (req_valid) begin
            resp_d.valid  = 1'b1;
            resp_d.grant  = ev_grant;
            resp_d.reason = ev_reason;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) resp_q <= '0;
        else        resp_q <= resp_d;
    end

    assign resp_valid  = resp_q.valid;
    assign resp_grant  = resp_q.grant;
    assign resp_reason = resp_q.reason;

endmodule

// File: rtl/periph_gate_chk.sv
module periph_gate_chk
    import periph_gate_pkg::*;
#(
    parameter int NUM_ENTRIES = 40,
    parameter int IDX_W       = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [IDX_W-1:0] req_idx,
    input logic             req_secure,
    input cfg_t             lk_cfg,
    input logic             lk_sec,
    input logic             resp_valid,
    input logic             resp_grant,
    input logic [2:0]       resp_reason
);
    // R4
    resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (resp_valid == $past(req_valid)));

    // R4
    grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_grant |-> resp_valid);

    // R4
    reason_zero_on_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_grant == (resp_reason == 3'd0)));

    // R5
    range_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && (int'($past(req_idx)) >= NUM_ENTRIES))
        |-> (!resp_grant && resp_reason == 3'd1));

    // R11
    secure_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && $past(lk_sec) && !$past(req_secure))
        |-> !resp_grant);

    // R6
    unfiltered_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(req_valid) && (int'($past(req_idx)) < NUM_ENTRIES)
         && !$past(lk_cfg.flt_en) && ($past(req_secure) || !$past(lk_sec)))
        |-> resp_grant);

endmodule

bind periph_gate periph_gate_chk #(
    .NUM_ENTRIES (NUM_ENTRIES),
    .IDX_W       (IDX_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .req_idx     (req_idx),
    .req_secure  (req_secure),
    .lk_cfg      (lk_cfg),
    .lk_sec      (lk_sec),
    .resp_valid  (resp_valid),
    .resp_grant  (resp_grant),
    .resp_reason (resp_reason)
);

// File: tb/periph_gate_tb.sv
`timescale 1ns/1ps
module periph_gate_tb;
    localparam int N  = 40;
    localparam int IW = 6;

    logic          clk = 0;
    logic          rst_n = 0;
    logic          cfg_wr = 0, cfg_sel = 0;
    logic [IW-1:0] cfg_addr = '0;
    logic [31:0]   cfg_wdata = '0, cfg_rdata;
    logic          req_valid = 0, req_secure = 0, sem_busy = 0;
    logic [IW-1:0] req_idx = '0;
    logic [2:0]    req_cid = '0, sem_cid = '0;
    logic          resp_valid, resp_grant;
    logic [2:0]    resp_reason;

    int checks = 0, fails = 0, cycles = 0;

    always #4 clk = ~clk;

    periph_gate #(.NUM_ENTRIES(N), .IDX_W(IW)) u_dut (.*);

    // behavioural model state
    int unsigned mcfg [64];
    int unsigned msec [2];
    int e_valid = 0, e_grant = 0, e_reason = 0;

    function automatic int model_reason(int idx, int cid, int sec, int busy, int hcid);
        int unsigned w;
        bit semm;
        if (idx >= N) return 1;
        w = mcfg[idx];
        semm = (w & 3) == 3;
        if (semm) begin
            if (((w >> (16 + cid)) & 1) == 0) return 3;
        end else if ((w & 1) && ((w >> 4) & 7) != 0 && ((w >> 4) & 7) != cid) return 2;
        if (!sec && ((msec[idx / 32] >> (idx % 32)) & 1)) return 4;
        if (semm && !(busy && hcid == cid)) return 5;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (mcfg[i]) mcfg[i] <= 0;
            msec[0] <= 0; msec[1] <= 0;
            e_valid <= 0; e_grant <= 0; e_reason <= 0;
        end else begin
            if (req_valid) begin
                int r;
                r = model_reason(int'(req_idx), int'(req_cid), int'(req_secure),
                                 int'(sem_busy), int'(sem_cid));
                e_valid <= 1; e_reason <= r; e_grant <= (r == 0);
            end else begin
                e_valid <= 0; e_grant <= 0; e_reason <= 0;
            end
            if (cfg_wr) begin
                if (!cfg_sel && cfg_addr < N) mcfg[cfg_addr] <= cfg_wdata & 32'h00FF_0073;
                else if (cfg_sel && cfg_addr < 2) msec[cfg_addr] <= cfg_wdata;
            end
        end
    end

    function automatic string tag_of(int r);
        case (r)
            1: return "R5";
            2: return "R8";
            3: return "R9";
            4: return "R11";
            5: return "R10";
            default: return "R4";
        endcase
    endfunction

    // compare on every clock, away from the active edge
    always @(negedge clk) begin
        cycles++;
        checks++;
        if (resp_valid !== 1'(e_valid) || resp_grant !== 1'(e_grant) ||
            resp_reason !== 3'(e_reason)) begin
            fails++;
            $display("FAIL %s: got v=%0b g=%0b r=%0d expected v=%0d g=%0d r=%0d",
                     (!rst_n) ? "R1" : tag_of(e_reason), resp_valid, resp_grant,
                     resp_reason, e_valid, e_grant, e_reason);
        end
    end

    task automatic wr(input bit sel, input int addr, input logic [31:0] d);
        @(negedge clk);
        cfg_wr = 1; cfg_sel = sel; cfg_addr = IW'(addr); cfg_wdata = d;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic rd_chk(input bit sel, input int addr, input logic [31:0] exp, input string tag);
        @(negedge clk);
        cfg_sel = sel; cfg_addr = IW'(addr);
        #2;
        checks++;
        if (cfg_rdata !== exp) begin
            fails++;
            $display("FAIL %s: readback sel=%0d addr=%0d got %h expected %h",
                     tag, sel, addr, cfg_rdata, exp);
        end
    endtask

    task automatic rq(input int idx, input int cid, input bit sec, input bit busy, input int hcid);
        @(negedge clk);
        req_valid = 1; req_idx = IW'(idx); req_cid = 3'(cid);
        req_secure = sec; sem_busy = busy; sem_cid = 3'(hcid);
        @(negedge clk);
        req_valid = 0;
    endtask

    initial begin
        int unsigned lfsr;
        repeat (5) @(negedge clk);
        rst_n = 1;
        // R1: reset contents and open access
        rd_chk(0, 3, 32'h0, "R1");
        rd_chk(1, 0, 32'h0, "R1");
        rq(5, 3, 0, 0, 0);
        // R2: field masking and out-of-range index
        wr(0, 7, 32'hFFFF_FFFF);
        rd_chk(0, 7, 32'h00FF_0073, "R2");
        wr(0, 45, 32'h0000_FFFF);
        rd_chk(0, 45, 32'h0, "R2");
        // R3: secure-only packing, peripheral 35 is reg 1 bit 3
        wr(1, 1, 32'h0000_0008);
        rd_chk(1, 1, 32'h0000_0008, "R3");
        wr(1, 2, 32'hFFFF_FFFF);
        rd_chk(1, 2, 32'h0, "R3");
        rq(35, 1, 0, 0, 0);   // R11 deny
        rq(35, 1, 1, 0, 0);   // R11 secure passes
        rq(3, 1, 0, 0, 0);    // R3 other register untouched
        // R5
        rq(40, 0, 1, 0, 0);
        rq(63, 2, 1, 0, 0);
        // R6: semaphore-enable alone, owner 5
        wr(0, 10, 32'h0000_0052);
        rq(10, 1, 0, 0, 0);
        // R7: filter on, owner 0
        wr(0, 11, 32'h0000_0001);
        rq(11, 6, 0, 0, 0);
        // R8: owner 3
        wr(0, 12, 32'h0000_0031);
        rq(12, 3, 0, 0, 0);
        rq(12, 2, 0, 0, 0);
        // R9/R10: semaphore mode, owner 2, whitelist {1,4}
        wr(0, 13, 32'h0012_0023);
        rq(13, 4, 0, 1, 4);
        rq(13, 2, 0, 1, 2);   // R9 owner ignored
        rq(13, 1, 0, 1, 1);
        rq(13, 4, 0, 0, 4);   // R10 not taken
        rq(13, 4, 0, 1, 1);   // R10 other holder
        // R12: precedence
        wr(0, 14, 32'h0000_0031);
        wr(1, 0, 32'h0000_6000);
        rq(14, 2, 0, 0, 0);   // owner before secure
        rq(13, 4, 0, 0, 0);   // secure before holder
        rq(13, 4, 1, 0, 0);   // holder when secure
        // R4: back-to-back requests
        @(negedge clk);
        for (int i = 0; i < 6; i++) begin
            req_valid = 1; req_idx = IW'(10 + i); req_cid = 3'(i); req_secure = 0;
            @(negedge clk);
        end
        req_valid = 0;
        // mixed traffic against the model
        lfsr = 32'hACE1_2345;
        for (int i = 0; i < 300; i++) begin
            lfsr = lfsr * 1664525 + 1013904223;
            @(negedge clk);
            if (lfsr[31:29] == 3'd0) begin
                cfg_wr = 1; cfg_sel = lfsr[28]; cfg_addr = IW'(lfsr[27:22] % 48);
                cfg_wdata = {lfsr[15:0], lfsr[31:16]};
            end else cfg_wr = 0;
            req_valid = lfsr[5]; req_idx = IW'(lfsr[21:16] % 48);
            req_cid = lfsr[8:6]; req_secure = lfsr[9];
            sem_busy = lfsr[10]; sem_cid = lfsr[13:11];
        end
        @(negedge clk);
        cfg_wr = 0; req_valid = 0;
        repeat (3) @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #(8 * 20000);
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule